// File: doc/BRIEF.md
# Two-Stage Management Watchdog

This block is a management watchdog for a slow, prescaled time base. A software agent on the operating-system side reloads the main down-counter at regular intervals. If the agent stops doing so, the main counter reaches its end and raises a single-cycle system-management interrupt (SMI) request, so that firmware can take over and try to recover. That first expiry arms a second counter of fixed length. If nothing reloads the main counter before the second counter runs out, the block raises a platform reset request. A configuration input can mask that request, in which case only a status flag records the event.

Two software strobes give a direct path from each side to the other. The operating-system side can raise an SMI request, and the firmware side can raise an interrupt that the operating system sees. Each timeout leaves a sticky status flag. Software clears a flag by writing one to it. The second-timeout flag lives in the power-on reset domain, so it survives the reset that the block itself requests and stays available for diagnosis after that reset.

All counting advances only on cycles where the time-base strobe is high. One strobe is one tick. The length of the second stage is a build-time tick count, chosen so that it equals 2.4 s at the tick rate in use.

Top module: `mgmt_watchdog`

## Requirements
- R1: While `rst_ni` is low, `smi_o`, `osint_o`, `rst_req_o` and `first_to_o` are 0, and the main counter is loaded with `INIT_TICKS`. After `rst_ni` is released, the INIT_TICKS-th tick produces an SMI pulse.
- R2: A one-cycle `reload_i` samples `reload_val_i` and restarts the main count. Call the sampled value N. The N-th tick after the reload makes `smi_o` high in the cycle after that tick and sets `first_to_o`. No earlier tick does either.
- R3: A sampled reload value of 0 counts as 1, so the first tick after such a reload expires the main counter.
- R4: The second counter does not run before a first timeout. Once the main counter expires, the second counter expires on the `S2_TICKS`-th tick after the expiry tick.
- R5: A reload at any point before the second counter expires stops and clears the second counter. No reset request follows.
- R6: When the second counter expires, `second_to_o` is set. `rst_req_o` also goes high and stays high until `rst_ni` is asserted, unless `no_reboot_i` is 1 in the expiry cycle. In that case `rst_req_o` stays 0.
- R7: A one-cycle `sw_smi_i` makes `smi_o` high in the next cycle. A one-cycle `sw_osint_i` makes `osint_o` high in the next cycle.
- R8: `smi_o` and `osint_o` are single-cycle pulses. Each event drops back to 0 one cycle later.
- R9: If a reload and the expiring tick occur in the same cycle, the reload wins. No SMI is raised, `first_to_o` is not set, and the count restarts from the new value.
- R10: `first_to_o` and `second_to_o` stay set until software writes one to `clr_first_i` or `clr_second_i`. If a set and a clear occur in the same cycle, the set wins.
- R11: `second_to_o` is not changed by `rst_ni`. Only `por_ni` low clears it.
- R12: After the main counter expires, it stays at zero and raises no further SMI until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset, the only reset that clears the second-timeout flag |
| tick_i | input | 1 | Prescaled time-base strobe, one tick per high cycle |
| reload_i | input | 1 | Reload strobe for the main counter |
| reload_val_i | input | CNT_W | Main counter reload value in ticks |
| no_reboot_i | input | 1 | When 1, the second timeout raises no reset request |
| sw_smi_i | input | 1 | OS-side strobe that raises an SMI request |
| sw_osint_i | input | 1 | Firmware-side strobe that raises an OS interrupt |
| clr_first_i | input | 1 | Write-one-to-clear strobe for the first-timeout flag |
| clr_second_i | input | 1 | Write-one-to-clear strobe for the second-timeout flag |
| smi_o | output | 1 | SMI request pulse |
| osint_o | output | 1 | OS interrupt request pulse |
| rst_req_o | output | 1 | Platform reset request, held until `rst_ni` is asserted |
| first_to_o | output | 1 | Sticky first-timeout flag |
| second_to_o | output | 1 | Sticky second-timeout flag |

## Verification
A wrong main count shows up as an SMI pulse on the wrong tick. Because every vector runs its count to completion, the error appears at the latest on the tick where the pulse should have come. A second counter that is armed when it should be idle, or that was not cleared, shows up as a reset request or second-timeout flag appearing before or after exactly `S2_TICKS` ticks. That is visible within one second-stage window. Errors in status or reset-domain state show up in the cycle right after a clear strobe, a `rst_ni` pulse or a `por_ni` pulse, because the flags are sampled directly after each of these.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic main_exp;
    logic s2_exp;
  } wdt_evt_t;
endpackage

// File: rtl/wdt_main_ctr.sv
module wdt_main_ctr #(
  parameter int CNT_W      = 8,
  parameter int INIT_TICKS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] InitVal = (INIT_TICKS < 1) ? CNT_W'(1) : CNT_W'(INIT_TICKS);
  localparam logic [CNT_W-1:0] One     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= InitVal;
    end else if (reload_i) begin
      cnt_q <= (reload_val_i == '0) ? One : reload_val_i;
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - One;
    end
  end

  // Reload takes priority over expiry
  assign expire_o = tick_i && !reload_i && (cnt_q == One);
endmodule

// File: rtl/wdt_stage2_ctr.sv
module wdt_stage2_ctr #(
  parameter int S2_TICKS = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic arm_i,
  input  logic stop_i,
  output logic expire_o
);
  localparam int              S2W  = $clog2(S2_TICKS + 1);
  localparam logic [S2W-1:0]  Last = S2W'(S2_TICKS - 1);

  logic           armed_q;
  logic [S2W-1:0] cnt_q;
  logic           hit;

  assign hit      = armed_q && tick_i && (cnt_q == Last);
  assign expire_o = hit && !stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (stop_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (hit) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (armed_q && tick_i) begin
      cnt_q   <= cnt_q + S2W'(1);
    end
  end
endmodule

// File: rtl/wdt_irq_status.sv
module wdt_irq_status
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     por_ni,
  input  wdt_evt_t evt_i,
  input  logic     no_reboot_i,
  input  logic     sw_smi_i,
  input  logic     sw_osint_i,
  input  logic     clr_first_i,
  input  logic     clr_second_i,
  output logic     smi_o,
  output logic     osint_o,
  output logic     rst_req_o,
  output logic     first_to_o,
  output logic     second_to_o
);
  logic smi_q, osint_q, rst_q, first_q, second_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smi_q   <= 1'b0;
      osint_q <= 1'b0;
      rst_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      smi_q   <= evt_i.main_exp | sw_smi_i;
      osint_q <= sw_osint_i;
      if (evt_i.s2_exp && !no_reboot_i) rst_q <= 1'b1;
      if (evt_i.main_exp)     first_q <= 1'b1;
      else if (clr_first_i)   first_q <= 1'b0;
    end
  end

  // Power-on domain: survives the requested reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      second_q <= 1'b0;
    end else if (rst_ni) begin
      if (evt_i.s2_exp)       second_q <= 1'b1;
      else if (clr_second_i)  second_q <= 1'b0;
    end
  end

  assign smi_o       = smi_q;
  assign osint_o     = osint_q;
  assign rst_req_o   = rst_q;
  assign first_to_o  = first_q;
  assign second_to_o = second_q;
endmodule

// File: rtl/mgmt_watchdog.sv
module mgmt_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int INIT_TICKS = 6,
  parameter int S2_TICKS   = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             no_reboot_i,
  input  logic             sw_smi_i,
  input  logic             sw_osint_i,
  input  logic             clr_first_i,
  input  logic             clr_second_i,
  output logic             smi_o,
  output logic             osint_o,
  output logic             rst_req_o,
  output logic             first_to_o,
  output logic             second_to_o
);
  wdt_evt_t evt;

  wdt_main_ctr #(.CNT_W(CNT_W), .INIT_TICKS(INIT_TICKS)) u_main (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .reload_i     (reload_i),
    .reload_val_i (reload_val_i),
    .expire_o     (evt.main_exp)
  );

  wdt_stage2_ctr #(.S2_TICKS(S2_TICKS)) u_stage2 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .arm_i    (evt.main_exp),
    .stop_i   (reload_i),
    .expire_o (evt.s2_exp)
  );

  wdt_irq_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_ni       (por_ni),
    .evt_i        (evt),
    .no_reboot_i  (no_reboot_i),
    .sw_smi_i     (sw_smi_i),
    .sw_osint_i   (sw_osint_i),
    .clr_first_i  (clr_first_i),
    .clr_second_i (clr_second_i),
    .smi_o        (smi_o),
    .osint_o      (osint_o),
    .rst_req_o    (rst_req_o),
    .first_to_o   (first_to_o),
    .second_to_o  (second_to_o)
  );
endmodule

// File: rtl/mgmt_watchdog_chk.sv
module mgmt_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic por_ni,
  input logic no_reboot_i,
  input logic sw_osint_i,
  input logic clr_first_i,
  input logic clr_second_i,
  input logic osint_o,
  input logic rst_req_o,
  input logic first_to_o,
  input logic second_to_o
);
  AST_RST_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o); // R6
  AST_RST_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> !$past(no_reboot_i)); // R6
  AST_RST_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(rst_req_o) |-> second_to_o); // R6
  AST_OSINT_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osint_o |-> $past(sw_osint_i)); // R7
  AST_OSINT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osint_o && !sw_osint_i) |=> !osint_o); // R8
  AST_FIRST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_to_o && !clr_first_i) |=> first_to_o); // R10
  AST_SECOND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (second_to_o && !clr_second_i) |=> second_to_o); // R10
endmodule

bind mgmt_watchdog mgmt_watchdog_chk u_chk (.*);

// File: tb/mgmt_watchdog_test.sv
module mgmt_watchdog_test;
  localparam int CNT_W = 8;
  localparam int INIT_TICKS = 6;
  localparam int S2_TICKS = 24;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0, por_ni = 1'b0;
  logic tick_i = 1'b0, reload_i = 1'b0, no_reboot_i = 1'b0;
  logic sw_smi_i = 1'b0, sw_osint_i = 1'b0, clr_first_i = 1'b0, clr_second_i = 1'b0;
  logic [CNT_W-1:0] reload_val_i = '0;
  logic smi_o, osint_o, rst_req_o, first_to_o, second_to_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  mgmt_watchdog #(.CNT_W(CNT_W), .INIT_TICKS(INIT_TICKS), .S2_TICKS(S2_TICKS)) uut (.*);

  // {reload value, tick on which SMI is expected}
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{0, 1}, '{1, 1}, '{2, 2}, '{7, 7}, '{130, 130}};

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask
  task automatic do_tick(); tick_i = 1'b1; cyc(); tick_i = 1'b0; endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) do_tick(); endtask
  task automatic do_reload(int v);
    reload_val_i = CNT_W'(v); reload_i = 1'b1; cyc(); reload_i = 1'b0;
  endtask
  task automatic pulse_clr_first(); clr_first_i = 1'b1; cyc(); clr_first_i = 1'b0; endtask
  task automatic pulse_clr_second(); clr_second_i = 1'b1; cyc(); clr_second_i = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int early;
    repeat (3) cyc();
    chk("R1 smi in reset", smi_o, 0);
    chk("R1 rst_req in reset", rst_req_o, 0);
    rst_ni = 1'b1; por_ni = 1'b1;
    cyc();
    chk("R1 first_to after reset", first_to_o, 0);
    chk("R11 second_to after por", second_to_o, 0);
    chk("R1 osint after reset", osint_o, 0);

    // R1: default count
    early = 0;
    for (int i = 0; i < INIT_TICKS - 1; i++) begin do_tick(); early |= smi_o; end
    chk("R1 no early smi", early, 0);
    do_tick();
    chk("R1 smi on INIT_TICKS", smi_o, 1);
    chk("R2 first_to set", first_to_o, 1);
    cyc();
    chk("R8 smi single cycle", smi_o, 0);
    early = 0;
    for (int i = 0; i < 10; i++) begin do_tick(); early |= smi_o; end
    chk("R12 main holds after expiry", early, 0);

    // Vector table: R2 and R3
    for (int v = 0; v < NV; v++) begin
      do_reload(200);
      pulse_clr_first();
      do_reload(VEC[v][0]);
      early = 0;
      for (int i = 0; i < VEC[v][1] - 1; i++) begin do_tick(); early |= smi_o; end
      chk(VEC[v][0] == 0 ? "R3 no early smi" : "R2 no early smi", early, 0);
      do_tick();
      chk(VEC[v][0] == 0 ? "R3 smi on tick" : "R2 smi on tick", smi_o, 1);
      chk("R2 first_to", first_to_o, 1);
    end
    do_reload(200);
    pulse_clr_first();

    // R4: second stage idle while reloads keep coming
    for (int i = 0; i < 10; i++) begin do_reload(10); ticks(5); end
    chk("R4 idle no rst_req", rst_req_o, 0);
    chk("R4 idle no second_to", second_to_o, 0);

    // R4/R6: second stage expiry
    do_reload(1); do_tick();
    chk("R4 first expiry", smi_o, 1);
    ticks(S2_TICKS - 1);
    chk("R4 no early rst_req", rst_req_o, 0);
    chk("R4 no early second_to", second_to_o, 0);
    do_tick();
    chk("R6 rst_req on S2_TICKS", rst_req_o, 1);
    chk("R6 second_to set", second_to_o, 1);
    ticks(3);
    chk("R6 rst_req held", rst_req_o, 1);
    rst_ni = 1'b0; cyc(); rst_ni = 1'b1; cyc();
    chk("R6 rst_req cleared by rst_ni", rst_req_o, 0);
    chk("R11 second_to survives rst_ni", second_to_o, 1);
    chk("R1 first_to cleared by rst_ni", first_to_o, 0);
    por_ni = 1'b0; cyc(); por_ni = 1'b1; cyc();
    chk("R11 second_to cleared by por", second_to_o, 0);

    // R5: reload stops second stage
    do_reload(1); do_tick();
    ticks(20);
    do_reload(100);
    ticks(30);
    chk("R5 no rst_req", rst_req_o, 0);
    chk("R5 no second_to", second_to_o, 0);

    // R6: masked reset
    no_reboot_i = 1'b1;
    do_reload(1); do_tick(); ticks(S2_TICKS);
    chk("R6 masked second_to", second_to_o, 1);
    chk("R6 masked rst_req", rst_req_o, 0);
    no_reboot_i = 1'b0;
    ticks(S2_TICKS + 2);
    chk("R6 no later rst_req", rst_req_o, 0);

    // R10: W1C
    pulse_clr_second();
    chk("R10 clear second_to", second_to_o, 0);
    pulse_clr_first();
    chk("R10 clear first_to", first_to_o, 0);
    do_reload(1);
    tick_i = 1'b1; clr_first_i = 1'b1; cyc(); tick_i = 1'b0; clr_first_i = 1'b0;
    chk("R10 set wins over clear", first_to_o, 1);

    // R9: reload beats expiry
    do_reload(1); pulse_clr_first();
    reload_val_i = CNT_W'(5); reload_i = 1'b1; tick_i = 1'b1; cyc();
    reload_i = 1'b0; tick_i = 1'b0;
    chk("R9 no smi", smi_o, 0);
    chk("R9 no first_to", first_to_o, 0);
    early = 0;
    for (int i = 0; i < 4; i++) begin do_tick(); early |= smi_o; end
    chk("R9 restart no early smi", early, 0);
    do_tick();
    chk("R9 restart smi", smi_o, 1);
    do_reload(200);

    // R7/R8: software strobes
    sw_smi_i = 1'b1; cyc(); sw_smi_i = 1'b0;
    chk("R7 sw smi", smi_o, 1);
    chk("R7 sw smi no osint", osint_o, 0);
    cyc();
    chk("R8 sw smi pulse", smi_o, 0);
    sw_osint_i = 1'b1; cyc(); sw_osint_i = 1'b0;
    chk("R7 sw osint", osint_o, 1);
    chk("R7 sw osint no smi", smi_o, 0);
    cyc();
    chk("R8 osint pulse", osint_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule